// File: doc/BRIEF.md
# 4:1:1 Chroma Nibble Deserializer

This block sits at the input of a video pipeline that receives component video in 4:1:1 form. The luma byte of every pixel arrives on its own bus, one sample per clock. The two colour-difference components share a narrow four-wire bus. Over four clocks each component delivers its byte as four 2-bit slices, most significant pair first. The block reassembles each U and V byte, keeps the four luma samples of the group, and plays the group back one pixel per clock. Each output pixel carries its own luma and the group's U and V, and a valid strobe marks it.

A line-start pulse aligns the groups: the sample presented with the pulse is always sample 0. Until the first pulse after reset, the block emits nothing. If a pulse cuts a group short, the fragment is dropped. Two format inputs describe how chroma is coded at the input and how it should be coded at the output. Each is either unsigned offset binary or two's complement. When they differ, the block converts by flipping the chroma sign bit.

Top module: `chroma_deser`

## Requirements
- R1: While reset is asserted and right after it, `valid_o` is 0 and `luma_o`, `u_o` and `v_o` are all zero.
- R2: Samples presented before the first `line_start_i` after reset never produce a valid output pixel.
- R3: The U byte of a group is rebuilt with chroma pin 3 as the odd bit and pin 2 as the even bit. Sample 0 carries U[7:6], sample 1 carries U[5:4], sample 2 carries U[3:2] and sample 3 carries U[1:0].
- R4: The V byte is rebuilt the same way from pins 1 (odd bit) and 0 (even bit), with V[7:6] in sample 0 down to V[1:0] in sample 3.
- R5: After a group's fourth sample, `valid_o` is high for four consecutive cycles. Across those cycles `luma_o` shows the group's four luma samples in arrival order.
- R6: Every valid output pixel appears exactly four clock cycles after its luma sample was presented at the input.
- R7: `u_o` and `v_o` stay unchanged across the four output pixels of a group.
- R8: When `in_twos_i` and `out_twos_i` differ, bit 7 of both U and V is inverted on output (1 = two's complement, 0 = offset binary). When they match, the bytes pass unchanged.
- R9: The format inputs take effect as sampled in the cycle of a group's fourth sample. Changing them while the group is being played out does not alter its output.
- R10: The sample presented in the same cycle as `line_start_i` is sample 0 of a new group.
- R11: A group cut short by `line_start_i` after one to three samples produces no valid output.
- R12: When `line_start_i` falls on what would have been a group's fourth sample, that sample starts a new group and the old fragment produces no output.
- R13: Groups presented back to back give an unbroken run of valid output pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start_i | input | 1 | Marks the current sample as sample 0 of a group |
| luma_i | input | 8 | Luma sample, one per clock |
| chroma_i | input | 4 | Chroma slice: [3:2] U bit pair, [1:0] V bit pair, odd bit on the higher pin |
| in_twos_i | input | 1 | Input chroma coding: 1 two's complement, 0 offset binary |
| out_twos_i | input | 1 | Output chroma coding: 1 two's complement, 0 offset binary |
| luma_o | output | 8 | Luma of the current output pixel |
| u_o | output | 8 | Reassembled, format-converted U of the current group |
| v_o | output | 8 | Reassembled, format-converted V of the current group |
| valid_o | output | 1 | High for each output pixel |

## Verification
Two things can happen in the same cycle. A line-start pulse can arrive while the previous group is still being played out, and it can land exactly where the old group would have taken its fourth sample. The bench provokes both cases with truncated groups of three and of two samples. Each truncated group is started right as an earlier group begins its playback. The run is judged in two ways. The earlier playback must finish intact. After it, `valid_o` must stay low until the new group's four pixels appear with its own luma, U and V, which would not happen if the fragment had been completed.

// File: rtl/chroma_deser_pkg.sv
package chroma_deser_pkg;

  localparam int DEF_DW  = 8;
  localparam int DEF_GRP = 4;

  // A coding change is needed only when the two sides disagree.
  function automatic logic flip_needed(input logic in_twos, input logic out_twos);
    return in_twos ^ out_twos;
  endfunction

endpackage

// File: rtl/cd_phase_ctr.sv
module cd_phase_ctr #(
  parameter int GRP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start_i,
  output logic grp_done_o
);
  localparam int PW = $clog2(GRP);
  localparam logic [PW-1:0] LAST = PW'(GRP - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] cur_idx;
  logic          armed_q;

  // The line-start sample is sample 0, whatever the running count says.
  always_comb begin
    cur_idx    = line_start_i ? '0 : phase_q;
    grp_done_o = (armed_q | line_start_i) && (cur_idx == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (line_start_i) armed_q <= 1'b1;
      phase_q <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
    end
  end

endmodule

// File: rtl/cd_gather.sv
module cd_gather #(
  parameter int DW  = 8,
  parameter int GRP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            luma_i,
  input  logic [2*(DW/GRP)-1:0]    chroma_i,
  output logic [GRP-1:0][DW-1:0]   grp_luma_o,
  output logic [DW-1:0]            u_full_o,
  output logic [DW-1:0]            v_full_o
);
  localparam int SL  = DW / GRP;
  localparam int CBW = 2 * SL;
  localparam int AW  = DW - SL;

  // Append the newest slice below the bits already gathered.
  function automatic logic [DW-1:0] push_slice(input logic [AW-1:0] acc,
                                               input logic [SL-1:0] s);
    return {acc, s};
  endfunction

  logic [AW-1:0]            u_acc_q, v_acc_q;
  logic [GRP-2:0][DW-1:0]   hist_q;

  always_comb begin
    u_full_o = push_slice(u_acc_q, chroma_i[CBW-1:SL]);
    v_full_o = push_slice(v_acc_q, chroma_i[SL-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_acc_q <= '0;
      v_acc_q <= '0;
    end else begin
      u_acc_q <= u_full_o[AW-1:0];
      v_acc_q <= v_full_o[AW-1:0];
    end
  end

  // Luma history: entry 0 is the oldest sample of the group.
  for (genvar k = 0; k < GRP - 1; k++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[k] <= '0;
      else if (k == GRP - 2) hist_q[k] <= luma_i;
      else hist_q[k] <= hist_q[k+1];
    end
    assign grp_luma_o[k] = hist_q[k];
  end
  assign grp_luma_o[GRP-1] = luma_i;

endmodule

// File: rtl/cd_out_bank.sv
module cd_out_bank #(
  parameter int DW  = 8,
  parameter int GRP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [GRP-1:0][DW-1:0] grp_luma_i,
  input  logic [DW-1:0]          u_i,
  input  logic [DW-1:0]          v_i,
  input  logic                   in_twos_i,
  input  logic                   out_twos_i,
  output logic [DW-1:0]          luma_o,
  output logic [DW-1:0]          u_o,
  output logic [DW-1:0]          v_o,
  output logic                   valid_o
);
  import chroma_deser_pkg::*;

  localparam int PW = $clog2(GRP);
  localparam int CW = $clog2(GRP + 1);

  // Offset binary and two's complement differ only in the sign bit.
  function automatic logic [DW-1:0] fmt_fix(input logic [DW-1:0] c, input logic flip);
    return c ^ {flip, {(DW-1){1'b0}}};
  endfunction

  logic [GRP-1:0][DW-1:0] bank_q;
  logic [DW-1:0]          u_q, v_q;
  logic [PW-1:0]          idx_q;
  logic [CW-1:0]          left_q;
  logic                   flip;

  assign flip = flip_needed(in_twos_i, out_twos_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      u_q    <= '0;
      v_q    <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      bank_q <= grp_luma_i;
      u_q    <= fmt_fix(u_i, flip);
      v_q    <= fmt_fix(v_i, flip);
      idx_q  <= '0;
      left_q <= CW'(GRP);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    luma_o  = bank_q[idx_q];
    u_o     = u_q;
    v_o     = v_q;
    valid_o = (left_q != '0);
  end

endmodule

// File: rtl/chroma_deser.sv
module chroma_deser #(
  parameter int DW  = chroma_deser_pkg::DEF_DW,
  parameter int GRP = chroma_deser_pkg::DEF_GRP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_start_i,
  input  logic [DW-1:0]           luma_i,
  input  logic [2*(DW/GRP)-1:0]   chroma_i,
  input  logic                    in_twos_i,
  input  logic                    out_twos_i,
  output logic [DW-1:0]           luma_o,
  output logic [DW-1:0]           u_o,
  output logic [DW-1:0]           v_o,
  output logic                    valid_o
);
  logic                   grp_done;
  logic [GRP-1:0][DW-1:0] grp_luma;
  logic [DW-1:0]          u_full, v_full;

  cd_phase_ctr #(.GRP(GRP)) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start_i),
    .grp_done_o   (grp_done)
  );

  cd_gather #(.DW(DW), .GRP(GRP)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .luma_i     (luma_i),
    .chroma_i   (chroma_i),
    .grp_luma_o (grp_luma),
    .u_full_o   (u_full),
    .v_full_o   (v_full)
  );

  cd_out_bank #(.DW(DW), .GRP(GRP)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (grp_done),
    .grp_luma_i (grp_luma),
    .u_i        (u_full),
    .v_i        (v_full),
    .in_twos_i  (in_twos_i),
    .out_twos_i (out_twos_i),
    .luma_o     (luma_o),
    .u_o        (u_o),
    .v_o        (v_o),
    .valid_o    (valid_o)
  );

endmodule

// File: rtl/chroma_deser_chk.sv
module chroma_deser_chk #(
  parameter int DW  = 8,
  parameter int GRP = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  line_start_i,
  input logic [DW-1:0]         luma_i,
  input logic [2*(DW/GRP)-1:0] chroma_i,
  input logic                  in_twos_i,
  input logic                  out_twos_i,
  input logic [DW-1:0]         luma_o,
  input logic [DW-1:0]         u_o,
  input logic [DW-1:0]         v_o,
  input logic                  valid_o,
  input logic                  grp_done
);
  localparam int SL  = DW / GRP;
  localparam int CBW = 2 * SL;
  localparam int PW  = $clog2(GRP);

  logic          seen_ls;
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_ls <= 1'b0;
      pos     <= '0;
    end else begin
      if (line_start_i) seen_ls <= 1'b1;
      pos <= valid_o ? pos + 1'b1 : '0;
    end
  end

  assert_idle_until_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_ls |-> !valid_o);

  assert_done_opens_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> valid_o);

  assert_uv_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && pos != '0) |-> ($stable(u_o) && $stable(v_o)));

  if (GRP == 4) begin : g_four
    assert_fixed_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (luma_o == $past(luma_i, 4)));

    assert_u_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pos == '0) |->
        (u_o == ({$past(chroma_i[CBW-1:SL], 4), $past(chroma_i[CBW-1:SL], 3),
                  $past(chroma_i[CBW-1:SL], 2), $past(chroma_i[CBW-1:SL], 1)}
                 ^ {$past(in_twos_i ^ out_twos_i, 1), {(DW-1){1'b0}}})));

    assert_v_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pos == '0) |->
        (v_o == ({$past(chroma_i[SL-1:0], 4), $past(chroma_i[SL-1:0], 3),
                  $past(chroma_i[SL-1:0], 2), $past(chroma_i[SL-1:0], 1)}
                 ^ {$past(in_twos_i ^ out_twos_i, 1), {(DW-1){1'b0}}})));

    // R11 and R12: a burst never opens on a group that a pulse interrupted.
    assert_no_fragment_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && pos == '0) |->
        (!$past(line_start_i, 1) && !$past(line_start_i, 2) && !$past(line_start_i, 3)));
  end

endmodule

bind chroma_deser chroma_deser_chk #(.DW(DW), .GRP(GRP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_start_i (line_start_i),
  .luma_i       (luma_i),
  .chroma_i     (chroma_i),
  .in_twos_i    (in_twos_i),
  .out_twos_i   (out_twos_i),
  .luma_o       (luma_o),
  .u_o          (u_o),
  .v_o          (v_o),
  .valid_o      (valid_o),
  .grp_done     (grp_done)
);

// File: tb/chroma_deser_test.sv
module chroma_deser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start_i = 1'b0;
  logic [7:0] luma_i = '0;
  logic [3:0] chroma_i = '0;
  logic       in_twos_i = 1'b0;
  logic       out_twos_i = 1'b0;
  logic [7:0] luma_o, u_o, v_o;
  logic       valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chroma_deser uut (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
    .luma_i(luma_i), .chroma_i(chroma_i),
    .in_twos_i(in_twos_i), .out_twos_i(out_twos_i),
    .luma_o(luma_o), .u_o(u_o), .v_o(v_o), .valid_o(valid_o)
  );

  // {y0, y1, y2, y3, u, v, in_twos, out_twos}
  localparam logic [49:0] VECS [6] = '{
    {8'h10, 8'h20, 8'h30, 8'h40, 8'h8C, 8'h3A, 1'b0, 1'b0},
    {8'hFF, 8'h00, 8'h7F, 8'h80, 8'h00, 8'hFF, 1'b0, 1'b1},
    {8'h01, 8'h02, 8'h03, 8'h04, 8'hF0, 8'h0F, 1'b1, 1'b0},
    {8'hA5, 8'h5A, 8'hC3, 8'h3C, 8'h96, 8'h69, 1'b1, 1'b1},
    {8'h11, 8'h22, 8'h33, 8'h44, 8'h80, 8'h7F, 1'b1, 1'b0},
    {8'hEE, 8'hDD, 8'hCC, 8'hBB, 8'h1B, 8'hE4, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic ls, input logic [7:0] y, input logic [3:0] c,
                      input logic it, input logic ot);
    @(negedge clk);
    line_start_i = ls;
    luma_i       = y;
    chroma_i     = c;
    in_twos_i    = it;
    out_twos_i   = ot;
  endtask

  // Slice k of a group: {U odd, U even, V odd, V even}, MSB pair first.
  function automatic logic [3:0] enc(input logic [7:0] u, input logic [7:0] v, input int k);
    return {u[7-2*k], u[6-2*k], v[7-2*k], v[6-2*k]};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // p junk samples (a fragment when p>0), then one full group, then four
  // filler samples during which the group is played out and checked.
  task automatic grp(input int p, input logic [49:0] vec, input string tag);
    logic [7:0] y [4];
    logic [7:0] u, v, ue, ve;
    logic it, ot;
    y[0] = vec[49:42]; y[1] = vec[41:34]; y[2] = vec[33:26]; y[3] = vec[25:18];
    u = vec[17:10]; v = vec[9:2]; it = vec[1]; ot = vec[0];
    ue = u ^ ((it != ot) ? 8'h80 : 8'h00);
    ve = v ^ ((it != ot) ? 8'h80 : 8'h00);
    for (int i = 0; i < p; i++)
      tick(i == 0, 8'(8'hA0 + i), 4'hF, it, ot);
    for (int k = 0; k < 4; k++) begin
      tick(k == 0, y[k], enc(u, v, k), it, ot);
      if (p + k >= 4) check({tag, " R11 R12 fragment gives no valid"}, {7'b0, valid_o}, 8'h00);
    end
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 8'h55, 4'h9, ~it, ot);   // format flip here tests R9
      check({tag, " R5 valid"}, {7'b0, valid_o}, 8'h01);
      check({tag, " R5 R6 R10 luma"}, luma_o, y[k]);
      check({tag, " R3 R7 R8 R9 u"}, u_o, ue);
      check({tag, " R4 R7 R8 R9 v"}, v_o, ve);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {7'b0, valid_o}, 8'h00);
    check("R1 luma in reset", luma_o, 8'h00);
    check("R1 u in reset", u_o, 8'h00);
    check("R1 v in reset", v_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {7'b0, valid_o}, 8'h00);
    check("R1 luma after reset", luma_o, 8'h00);

    // R2: samples before any line start produce nothing
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, 8'(8'h60 + i), 4'(i + 5), 1'b0, 1'b1);
      check("R2 no output before line start", {7'b0, valid_o}, 8'h00);
    end

    // Table walk: aligned groups under varied data and formats
    foreach (VECS[n]) grp(0, VECS[n], "table");

    // R12: pulse on the fourth position of a fragment
    grp(3, {8'h91, 8'h92, 8'h93, 8'h94, 8'hC6, 8'h27, 1'b0, 1'b1}, "cut at 3");
    // R11: fragment of two samples
    grp(2, {8'h71, 8'h72, 8'h73, 8'h74, 8'h4D, 8'hB2, 1'b1, 1'b0}, "cut at 2");

    // R13: the filler group runs straight on after the last checked group
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 8'h00, 4'h0, 1'b0, 1'b0);
      check("R13 back-to-back valid", {7'b0, valid_o}, 8'h01);
      check("R13 back-to-back luma", luma_o, 8'h55);
    end

    summary();
  end

endmodule